// File: doc/BRIEF.md
# Watchdog Timer with Selectable Tick

A bus-attached watchdog for a system controller. Software programs a 16-bit timeout in ticks. It picks one of four tick resolutions and whether expiry asks for a system reset or a shutdown. It then sets a run bit and must keep writing a reload bit before the timeout runs out. When the countdown runs out, the block latches a fired flag and pulses one request output for a single cycle. The counter then stays stopped.

Software reaches the block through a plain word-addressed write strobe and a combinational read mux. Four 32-bit registers sit at offsets 0x0 (control), 0x4 (timeout), 0x8 (configuration) and 0xC (status). The tick periods are parameters, given in cycles of `clk_i`. A reset-cause flag in the status register is kept across the system reset that the watchdog itself requests. Only the power-on reset or a write of 1 clears it.

Top module: `wdog_tick_timer`

## Requirements
- R1: After power-on reset, control reads 0x08 (disable status bit3 = 1), timeout reads 0, configuration reads 0x1 (bit0 disable = 1, bits 2:1 select = 00), status reads 0, and both request outputs are low.
- R2: A write to the timeout register at 0x4 keeps bits 15:0, and the register reads back with bits 31:16 as zero.
- R3: Control bits are bit0 run, bit1 fired, bit2 shutdown action, bit3 disable status, and bit7 reload. Bit7 and bits 6:4 always read 0.
- R4: With timeout N and tick period P, a request pulse appears exactly N*P cycles after the edge that captures the reload or run-start write (P cycles when N is 0). It lasts one cycle, and the fired bit is set at the same edge.
- R5: Configuration select 00, 01, 10 and 11 give tick periods of TICK_FINE_CYC, TICK_10MS_CYC, TICK_100MS_CYC and TICK_1S_CYC cycles.
- R6: With control bit2 = 1, expiry pulses `shutdown_req_o` instead of `reset_req_o` and leaves the reset-cause bit unchanged. The two requests are never high together.
- R7: Writing 1 to control bit1 clears fired, and writing 0 to it leaves fired unchanged.
- R8: Status bit1 is set when expiry issues a reset request. It is kept through `rst_ni`, cleared by writing 1 to status bit1, and cleared by `por_ni`.
- R9: While configuration bit0 is 1, the run bit cannot be set and no request is issued. Setting bit0 also clears a run bit that was already set.
- R10: Clearing the run bit stops the countdown, so no request follows.
- R11: A reload restarts both the countdown and the tick prescaler, so reloads written faster than the timeout prevent expiry.
- R12: After expiry the countdown stays stopped and no further request occurs until a reload or a new run start.
- R13: Writing a different tick select restarts the prescaler, so the next tick is one full new period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the tick reference |
| rst_ni | input | 1 | Active-low async system reset (keeps reset cause) |
| por_ni | input | 1 | Active-low async power-on reset (clears everything) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| reset_req_o | output | 1 | One-cycle reset request on expiry |
| shutdown_req_o | output | 1 | One-cycle shutdown request on expiry |

## Verification
Register reads are combinational, so the bench samples `rdata_o` 1 ns after setting `addr_i`. A register write takes effect at the edge that captures it. The request pulse is registered and is due right after edge E + N*P, where E is the edge that captured the reload, run-start or tick-select write. The bench counts N*P edges from E and samples 1 ns after each edge. It requires the outputs to be quiet up to that point, high exactly then, and low one edge later. A free-running negedge pulse counter checks the windows where no request may appear: disabled, stopped, reloaded early, and after expiry.

// File: rtl/wdog_tick_pkg.sv
package wdog_tick_pkg;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_CNT  = 4'h4;
  localparam logic [3:0] OFF_CFG  = 4'h8;
  localparam logic [3:0] OFF_STAT = 4'hC;

  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_FIRED  = 1;
  localparam int unsigned CB_SHUT   = 2;
  localparam int unsigned CB_DIS    = 3;
  localparam int unsigned CB_RELOAD = 7;

  localparam int unsigned FB_DIS = 0;
  localparam int unsigned FB_SEL = 1;
  localparam int unsigned SB_CAUSE = 1;

  typedef enum logic [1:0] {
    TICK_FINE  = 2'b00,
    TICK_10MS  = 2'b01,
    TICK_100MS = 2'b10,
    TICK_1S    = 2'b11
  } tick_sel_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_tick_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic              dis_o,
  output tick_sel_e         sel_o,
  output logic              shut_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              restart_o,
  output logic              sel_chg_o,
  output logic              fired_o,
  output logic              cause_o
);
  logic wr_ctrl, wr_cnt, wr_cfg, wr_stat;
  logic run_q, fired_q, shut_q, dis_q, cause_q;
  tick_sel_e sel_q;
  logic [CNT_W-1:0] load_q;
  logic run_start, reload;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_cnt  = wr_en_i && (addr_i == ADDR_W'(OFF_CNT));
  assign wr_cfg  = wr_en_i && (addr_i == ADDR_W'(OFF_CFG));
  assign wr_stat = wr_en_i && (addr_i == ADDR_W'(OFF_STAT));

  assign run_start = wr_ctrl && wdata_i[CB_RUN] && !run_q && !dis_q;
  assign reload    = wr_ctrl && wdata_i[CB_RELOAD];
  assign sel_chg_o = wr_cfg && (wdata_i[FB_SEL+:2] != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      shut_q  <= 1'b0;
      fired_q <= 1'b0;
      load_q  <= '0;
      dis_q   <= 1'b1;
      sel_q   <= TICK_FINE;
    end else begin
      if (wr_cfg && wdata_i[FB_DIS]) run_q <= 1'b0;
      else if (wr_ctrl)              run_q <= wdata_i[CB_RUN] && !dis_q;
      if (wr_ctrl) shut_q <= wdata_i[CB_SHUT];
      // set on expiry wins over a same-cycle clear
      if (expire_i)                              fired_q <= 1'b1;
      else if (wr_ctrl && wdata_i[CB_FIRED])     fired_q <= 1'b0;
      if (wr_cnt) load_q <= wdata_i[CNT_W-1:0];
      if (wr_cfg) begin
        dis_q <= wdata_i[FB_DIS];
        sel_q <= tick_sel_e'(wdata_i[FB_SEL+:2]);
      end
    end
  end

  // reset cause only sees the power-on reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                              cause_q <= 1'b0;
    else if (expire_i && !shut_q)             cause_q <= 1'b1;
    else if (wr_stat && wdata_i[SB_CAUSE])    cause_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL): begin
        rdata_o[CB_RUN]   = run_q;
        rdata_o[CB_FIRED] = fired_q;
        rdata_o[CB_SHUT]  = shut_q;
        rdata_o[CB_DIS]   = dis_q;
      end
      ADDR_W'(OFF_CNT):  rdata_o[CNT_W-1:0] = load_q;
      ADDR_W'(OFF_CFG): begin
        rdata_o[FB_DIS]     = dis_q;
        rdata_o[FB_SEL+:2]  = sel_q;
      end
      ADDR_W'(OFF_STAT): rdata_o[SB_CAUSE] = cause_q;
      default:           rdata_o = '0;
    endcase
  end

  assign run_o     = run_q;
  assign dis_o     = dis_q;
  assign sel_o     = sel_q;
  assign shut_o    = shut_q;
  assign load_o    = load_q;
  assign restart_o = run_start || reload;
  assign fired_o   = fired_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_tick_pkg::*;
#(
  parameter int unsigned TICK_FINE_CYC  = 3200,
  parameter int unsigned TICK_10MS_CYC  = 1000000,
  parameter int unsigned TICK_100MS_CYC = 10000000,
  parameter int unsigned TICK_1S_CYC    = 100000000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      restart_i,
  input  tick_sel_e sel_i,
  output logic      tick_o
);
  localparam int unsigned MAX_A = (TICK_FINE_CYC > TICK_10MS_CYC) ? TICK_FINE_CYC : TICK_10MS_CYC;
  localparam int unsigned MAX_B = (TICK_100MS_CYC > TICK_1S_CYC) ? TICK_100MS_CYC : TICK_1S_CYC;
  localparam int unsigned MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned PW    = (MAX_P < 2) ? 1 : $clog2(MAX_P);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;

  always_comb begin
    case (sel_i)
      TICK_FINE:  last = PW'(TICK_FINE_CYC - 1);
      TICK_10MS:  last = PW'(TICK_10MS_CYC - 1);
      TICK_100MS: last = PW'(TICK_100MS_CYC - 1);
      default:    last = PW'(TICK_1S_CYC - 1);
    endcase
  end

  assign tick_o = en_i && !restart_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i || !en_i || tick_o) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             halt_q;

  assign active_o = run_i && !halt_q;
  // a timeout of 0 or 1 runs out on the next tick
  assign expire_o = active_o && tick_i && (cur_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      halt_q <= 1'b0;
    end else if (restart_i) begin
      cur_q  <= load_i;
      halt_q <= 1'b0;
    end else if (expire_o) begin
      cur_q  <= '0;
      halt_q <= 1'b1;
    end else if (active_o && tick_i) begin
      cur_q  <= cur_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_tick_timer.sv
module wdog_tick_timer
  import wdog_tick_pkg::*;
#(
  parameter int unsigned ADDR_W         = 4,
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned TICK_FINE_CYC  = 3200,
  parameter int unsigned TICK_10MS_CYC  = 1000000,
  parameter int unsigned TICK_100MS_CYC = 10000000,
  parameter int unsigned TICK_1S_CYC    = 100000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              reset_req_o,
  output logic              shutdown_req_o
);
  logic sys_rst_n;
  logic run_w, dis_w, shut_w, restart_w, sel_chg_w, fired_w, cause_w;
  logic active_w, tick_w, expire_w;
  tick_sel_e sel_w;
  logic [CNT_W-1:0] load_w;
  logic rst_req_q, shut_req_q;

  assign sys_rst_n = rst_ni && por_ni;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .por_ni    (por_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .expire_i  (expire_w),
    .rdata_o   (rdata_o),
    .run_o     (run_w),
    .dis_o     (dis_w),
    .sel_o     (sel_w),
    .shut_o    (shut_w),
    .load_o    (load_w),
    .restart_o (restart_w),
    .sel_chg_o (sel_chg_w),
    .fired_o   (fired_w),
    .cause_o   (cause_w)
  );

  wdog_prescaler #(
    .TICK_FINE_CYC (TICK_FINE_CYC),
    .TICK_10MS_CYC (TICK_10MS_CYC),
    .TICK_100MS_CYC(TICK_100MS_CYC),
    .TICK_1S_CYC   (TICK_1S_CYC)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .en_i      (active_w),
    .restart_i (restart_w || sel_chg_w),
    .sel_i     (sel_w),
    .tick_o    (tick_w)
  );

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (sys_rst_n),
    .run_i     (run_w),
    .restart_i (restart_w),
    .load_i    (load_w),
    .tick_i    (tick_w),
    .active_o  (active_w),
    .expire_o  (expire_w)
  );

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rst_req_q  <= 1'b0;
      shut_req_q <= 1'b0;
    end else begin
      rst_req_q  <= expire_w && !shut_w;
      shut_req_q <= expire_w && shut_w;
    end
  end

  assign reset_req_o    = rst_req_q;
  assign shutdown_req_o = shut_req_q;
endmodule

// File: rtl/wdog_tick_timer_chk.sv
module wdog_tick_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic reset_req_o,
  input logic shutdown_req_o,
  input logic fired_i,
  input logic cause_i,
  input logic dis_i,
  input logic run_i
);
  // R6
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(reset_req_o && shutdown_req_o));
  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (reset_req_o || shutdown_req_o) |=> !(reset_req_o || shutdown_req_o));
  // R4
  fired_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (reset_req_o || shutdown_req_o) |-> fired_i);
  // R8
  cause_on_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reset_req_o |-> cause_i);
  // R9
  dis_blocks_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    dis_i |-> !run_i);
endmodule

bind wdog_tick_timer wdog_tick_timer_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .por_ni         (por_ni),
  .reset_req_o    (reset_req_o),
  .shutdown_req_o (shutdown_req_o),
  .fired_i        (fired_w),
  .cause_i        (cause_w),
  .dis_i          (dis_w),
  .run_i          (run_w)
);

// File: tb/wdog_tick_timer_bench.sv
`timescale 1ns/1ps
module wdog_tick_timer_bench;
  localparam int unsigned P0 = 4, P1 = 6, P2 = 9, P3 = 13;

  logic clk_i = 1'b0, rst_ni = 1'b0, por_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic reset_req_o, shutdown_req_o;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  wdog_tick_timer #(
    .TICK_FINE_CYC(P0), .TICK_10MS_CYC(P1), .TICK_100MS_CYC(P2), .TICK_1S_CYC(P3)
  ) u_wdog_tick_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .reset_req_o(reset_req_o), .shutdown_req_o(shutdown_req_o)
  );

  always @(negedge clk_i) if (reset_req_o || shutdown_req_o) pulses++;

  function automatic int unsigned period_f(input logic [1:0] s);
    case (s)
      2'd0: return P0;
      2'd1: return P1;
      2'd2: return P2;
      default: return P3;
    endcase
  endfunction

  function automatic int unsigned fire_f(input int unsigned n, input logic [1:0] s);
    return ((n == 0) ? 1 : n) * period_f(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; #1;
    d = rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // called right after the capture edge of the start write
  task automatic expect_fire(input string req, input int unsigned t, input bit shut);
    int early = 0;
    for (int i = 1; i < t; i++) begin
      @(posedge clk_i); #1;
      if (reset_req_o || shutdown_req_o) early++;
    end
    chk({req, " early"}, early, 0);
    @(posedge clk_i); #1;
    chk({req, " pulse"}, {reset_req_o, shutdown_req_o}, shut ? 2'b01 : 2'b10);
    @(posedge clk_i); #1;
    chk({req, " one cycle"}, {reset_req_o, shutdown_req_o}, 2'b00);
  endtask

  task automatic quiet(input string req, input int unsigned t);
    int p0 = pulses;
    repeat (t) @(posedge clk_i);
    #1;
    chk(req, pulses - p0, 0);
  endtask

  task automatic finish_sim;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      finish_sim();
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    #23 rst_ni = 1'b1; por_ni = 1'b1;
    #1;
    // R1
    rd_chk("R1 ctrl", 4'h0, 32'h08);
    rd_chk("R1 cnt", 4'h4, 32'h0);
    rd_chk("R1 cfg", 4'h8, 32'h1);
    rd_chk("R1 stat", 4'hC, 32'h0);
    chk("R1 reqs", {reset_req_o, shutdown_req_o}, 2'b00);

    wr(4'h8, 32'h0);
    // R2
    wr(4'h4, 32'hABCD_1234);
    rd_chk("R2 cnt mask", 4'h4, 32'h1234);
    wr(4'h4, 32'd3);
    // R4, R5 select 00
    wr(4'h0, 32'h1);
    expect_fire("R4 n=3 sel00", fire_f(3, 2'd0), 1'b0);
    // R3
    rd_chk("R3 ctrl readback", 4'h0, 32'h03);
    rd_chk("R8 cause set", 4'hC, 32'h2);
    // R12
    quiet("R12 halted after expiry", 40);
    // R7
    wr(4'h0, 32'h1);
    rd_chk("R7 write0 keeps fired", 4'h0, 32'h03);
    wr(4'h0, 32'h2);
    rd_chk("R7 W1C fired", 4'h0, 32'h00);
    // R8 survives system reset
    @(negedge clk_i); rst_ni = 1'b0; #3; rst_ni = 1'b1;
    rd_chk("R8 cause kept", 4'hC, 32'h2);
    rd_chk("R8 cfg after rst", 4'h8, 32'h1);
    wr(4'hC, 32'h2);
    rd_chk("R8 cause W1C", 4'hC, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'd0);
    wr(4'h0, 32'h81);
    expect_fire("R4 n=0", fire_f(0, 2'd0), 1'b0);
    rd_chk("R8 cause again", 4'hC, 32'h2);
    @(negedge clk_i); por_ni = 1'b0; #3; por_ni = 1'b1;
    rd_chk("R8 cause por", 4'hC, 32'h0);

    // R6 shutdown, select 01
    wr(4'h8, 32'h2);
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h85);
    expect_fire("R6 shutdown sel01", fire_f(2, 2'd1), 1'b1);
    rd_chk("R6 ctrl", 4'h0, 32'h07);
    rd_chk("R6 cause untouched", 4'hC, 32'h0);
    wr(4'h0, 32'h2);

    // R9
    wr(4'h8, 32'h1);
    wr(4'h0, 32'h81);
    rd_chk("R9 run blocked", 4'h0, 32'h08);
    quiet("R9 no req disabled", 60);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'd5);
    wr(4'h0, 32'h1);
    repeat (3) @(posedge clk_i);
    wr(4'h8, 32'h1);
    rd_chk("R9 disable clears run", 4'h0, 32'h08);
    quiet("R9 no req after disable", 60);

    // R10
    wr(4'h8, 32'h0);
    wr(4'h4, 32'd3);
    wr(4'h0, 32'h1);
    repeat (4) @(posedge clk_i);
    wr(4'h0, 32'h0);
    quiet("R10 stopped", 60);

    // R11
    wr(4'h0, 32'h1);
    for (int k = 0; k < 5; k++) begin
      repeat (6) @(posedge clk_i);
      wr(4'h0, 32'h81);
    end
    expect_fire("R11 fire after last reload", fire_f(3, 2'd0), 1'b0);
    wr(4'h0, 32'h2);

    // R13
    wr(4'h4, 32'd2);
    wr(4'h0, 32'h1);
    repeat (2) @(posedge clk_i);
    wr(4'h8, 32'h6);
    expect_fire("R13 sel change restarts", fire_f(2, 2'd3), 1'b0);
    wr(4'h0, 32'h2);
    wr(4'hC, 32'h2);

    // random mix, R4 R5 R6
    for (int it = 0; it < 10; it++) begin
      logic [1:0] s;
      int unsigned n;
      bit act;
      s = 2'($urandom_range(0, 3));
      n = $urandom_range(0, 5);
      act = 1'($urandom_range(0, 1));
      wr(4'h8, {29'd0, s, 1'b0});
      wr(4'h4, {$urandom, 16'h0} | n);
      wr(4'h0, 32'h81 | (32'(act) << 2));
      expect_fire($sformatf("R5 rand sel=%0d n=%0d R6 act=%0d", s, n, act), fire_f(n, s), act);
      rd_chk("R3 rand ctrl", 4'h0, 32'h03 | (32'(act) << 2));
      rd_chk("R8 rand cause", 4'hC, act ? 32'h0 : 32'h2);
      wr(4'h0, 32'h2);
      wr(4'hC, 32'h2);
    end
    quiet("R12 idle end", 30);

    done = 1;
    finish_sim();
  end
endmodule